// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block is the command decoder and protection logic of a serial flash slave. A host clocks bytes in over a four-wire serial interface in clock mode 0 or mode 3 while chip select is low. The block keeps an 8-bit status word and samples a hardware write-protect pin. When a frame ends it decides whether a state-changing command is granted or ignored.

A granted program, erase or status write keeps a busy flag high for a fixed number of system clocks. A simple countdown stands in for the storage array, so a host or a bench can poll until the flag drops. The serial pins are oversampled by the system clock, so the serial clock must run several times slower than `clk`.

Top module: `fsr_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising `clk` edge), the status word reads 0x00 and `busy` is low.
- R2: Status bit positions are fixed: bit 7 lock, bits 6 and 5 always 0, bits 4:2 protect level, bit 1 write-enable latch, bit 0 busy. Opcode 0x05 returns the status on `miso`, most significant bit first, valid at each rising `sck`. The status is re-captured at every byte boundary and repeated for as long as chip select stays low. `miso` is 0 while deselected.
- R3: One-byte frame 0x06 sets the write-enable latch and one-byte frame 0x04 clears it. A frame of any other length with these opcodes has no effect.
- R4: Frame 0x01 plus exactly one data byte, accepted, loads data bit 7 into the lock bit and data bits 4:2 into the protect level. It holds busy for `T_WRSR` cycles, and the write-enable latch drops when busy ends.
- R5: With the lock bit 1 and `wp_n` low, a status write is ignored and the write-enable latch stays set. With `wp_n` high, or the lock bit 0, the write is accepted.
- R6: Frame 0x02, a 24-bit address (most significant byte first) and 1 to 256 data bytes is a page program, busy for `T_PROG` cycles. A frame with 0 or more than 256 data bytes is ignored.
- R7: Frame 0x20 (sector) or 0x52 (block) plus a 24-bit address, exactly 4 bytes in all, is an erase, busy for `T_ERASE` cycles.
- R8: For a 128 KB array, protect level 0 guards nothing. Level 1 guards 0x18000-0x1FFFF, level 2 guards 0x10000-0x1FFFF, and levels 3 to 7 guard the whole array. A program or erase to a guarded address is ignored and leaves the write-enable latch set.
- R9: One-byte frame 0xC7 (whole-array erase) is granted only when the protect level is 0, and is then busy for `T_ERASE` cycles.
- R10: A status write, program or erase is ignored when the write-enable latch is 0.
- R11: A command acts only when chip select rises, and only if the frame held a whole, non-zero number of bytes.
- R12: While busy is high, every command except the status read is ignored.
- R13: `busy` rises on the third rising `clk` edge after the first edge that samples `cs_n` high. It stays high for exactly the cycle count of the granted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idle low (mode 0) or high (mode 3) |
| mosi | input | 1 | Serial data from host, sampled on rising `sck` |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| miso | output | 1 | Serial data to host (status read) |
| busy | output | 1 | Operation in progress, same as status bit 0 |

## Verification
A wrong latch or protect value inside the block becomes visible at the next status read, one byte after the opcode. It shows sooner when it changes whether the next command starts a busy window. A wrong grant decision or busy-counter load shows on `busy` within three clocks of chip select rising, or at the cycle the window should have closed. For this reason the bench compares `busy` against its model on every clock. It reads the status word after each command, and during a busy window as well, so a status-write or latch-clear error cannot hide behind the busy flag.

// File: rtl/fsr_pkg.sv
// Shared opcodes for the serial flash status/protect controller.
// Assumes byte-wide opcodes sent most significant bit first.
package fsr_pkg;
    typedef enum logic [7:0] {
        OP_WREN = 8'h06,
        OP_WRDI = 8'h04,
        OP_RDSR = 8'h05,
        OP_WRSR = 8'h01,
        OP_PP   = 8'h02,
        OP_SE   = 8'h20,
        OP_BE   = 8'h52,
        OP_CE   = 8'hC7
    } fsr_op_e;
endpackage

// File: rtl/fsr_spi_rx.sv
// Serial slave front end: synchronises the pins into clk, frames bytes,
// keeps opcode / address / first argument, and streams a status byte.
// Assumes sck slower than clk/6 and mosi stable around rising sck.
module fsr_spi_rx
    import fsr_pkg::*;
#(
    parameter int NB_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            mosi,
    input  logic [7:0]      status_i,
    output logic            miso,
    output logic            frame_end,
    output logic            whole,
    output logic [7:0]      opcode,
    output logic [23:0]     addr,
    output logic [7:0]      arg,
    output logic [NB_W-1:0] nbytes
);
    logic [2:0] cs_q, sck_q;
    logic [1:0] mosi_q;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic       rd_mode;
    logic [7:0] shadow;
    logic [7:0] nb_w;
    logic       sck_rise, deselected;

    assign sck_rise   = sck_q[1] & ~sck_q[2];
    assign frame_end  = cs_q[1] & ~cs_q[2];
    assign deselected = cs_q[1] & cs_q[2];
    assign nb_w       = {shreg, mosi_q[1]};
    assign whole      = (bit_cnt == 3'd0) && (nbytes != '0);
    assign miso       = rd_mode ? shadow[3'd7 - bit_cnt] : 1'b0;

    // Purpose: bring the asynchronous serial pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 3'b111;
            sck_q  <= 3'b000;
            mosi_q <= 2'b00;
        end else begin
            cs_q   <= {cs_q[1:0], cs_n};
            sck_q  <= {sck_q[1:0], sck};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    // Purpose: count bits and bytes, capture fields, refresh the status shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            nbytes  <= '0;
            opcode  <= '0;
            addr    <= '0;
            arg     <= '0;
            rd_mode <= 1'b0;
            shadow  <= '0;
        end else if (deselected) begin
            bit_cnt <= '0;
            nbytes  <= '0;
            rd_mode <= 1'b0;
        end else if (!cs_q[1] && sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            shreg   <= nb_w[6:0];
            if (bit_cnt == 3'd7) begin
                if (nbytes != '1)
                    nbytes <= nbytes + NB_W'(1);
                if (nbytes == '0)
                    opcode <= nb_w;
                if (nbytes == NB_W'(1))
                    arg <= nb_w;
                if (nbytes >= NB_W'(1) && nbytes <= NB_W'(3))
                    addr <= {addr[15:0], nb_w};
                if ((nbytes == '0) ? (nb_w == OP_RDSR) : rd_mode) begin
                    rd_mode <= 1'b1;
                    shadow  <= status_i;
                end
            end
        end
    end

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        deselected |=> !miso); // R2
endmodule

// File: rtl/fsr_prot_map.sv
// Protected-region decode: maps the 3-bit protect level and an address to
// a hit flag. Guards the top 1, 2, 4... blocks; level 4 and up guard all.
module fsr_prot_map #(
    parameter int ADDR_W  = 17,
    parameter int BLK_LOG = 15
) (
    input  logic [2:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int BLK_W = ADDR_W - BLK_LOG;
    localparam int NBLK  = 1 << BLK_W;

    // Purpose: number of guarded top blocks, then compare the block index.
    always_comb begin
        int nprot;
        if (level == 3'd0)
            nprot = 0;
        else if (level[2] || (int'(level) - 1 >= BLK_W))
            nprot = NBLK;
        else
            nprot = 1 << (int'(level) - 1);
        hit = (int'({1'b0, addr[ADDR_W-1:BLK_LOG]}) >= (NBLK - nprot));
    end
endmodule

// File: rtl/fsr_busy_timer.sv
// Stand-in for the array: a load-and-count-down timer. busy is high while
// the count is non-zero; done marks its last busy cycle. Load must be >= 1.
module fsr_busy_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    // Purpose: load on a grant, otherwise count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= load;
        else if (busy)
            cnt <= cnt - CNT_W'(1);
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R12
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R13
endmodule

// File: rtl/fsr_ctrl.sv
// Top: status word, write-enable latch, lock and protect level, and the
// grant decision made when chip select rises. Assumes wp_n changes slowly.
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BLK_LOG    = 15,
    parameter int PAGE_BYTES = 256,
    parameter int T_PROG     = 2000,
    parameter int T_ERASE    = 8000,
    parameter int T_WRSR     = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso,
    output logic busy
);
    localparam int T_A   = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
    localparam int T_MAX = (T_A > T_WRSR) ? T_A : T_WRSR;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int NB_W  = $clog2(PAGE_BYTES + 6);

    logic             lock_q, wel_q;
    logic [2:0]       level_q;
    logic [1:0]       wp_q;
    logic [7:0]       status;
    logic             frame_end, whole, done, prot_hit;
    logic [7:0]       opcode, arg;
    logic [23:0]      addr;
    logic [NB_W-1:0]  nbytes;
    logic             grant, set_wel, clr_wel, sr_write;
    logic [CNT_W-1:0] load;

    assign status = {lock_q, 2'b00, level_q, wel_q, busy};

    fsr_spi_rx #(.NB_W(NB_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .status_i(status), .miso(miso), .frame_end(frame_end), .whole(whole),
        .opcode(opcode), .addr(addr), .arg(arg), .nbytes(nbytes)
    );

    fsr_prot_map #(.ADDR_W(ADDR_W), .BLK_LOG(BLK_LOG)) u_map (
        .level(level_q), .addr(addr[ADDR_W-1:0]), .hit(prot_hit)
    );

    fsr_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(grant), .load(load),
        .busy(busy), .done(done)
    );

    // Purpose: synchronise the write-protect pin.
    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= 2'b11;
        else        wp_q <= {wp_q[0], wp_n};
    end

    // Purpose: decide the effect of a finished frame.
    always_comb begin
        grant    = 1'b0;
        set_wel  = 1'b0;
        clr_wel  = 1'b0;
        sr_write = 1'b0;
        load     = CNT_W'(T_ERASE);
        if (frame_end && whole && !busy) begin
            case (opcode)
                OP_WREN: set_wel = (nbytes == NB_W'(1));
                OP_WRDI: clr_wel = (nbytes == NB_W'(1));
                OP_WRSR: begin
                    sr_write = (nbytes == NB_W'(2)) && wel_q && !(lock_q && !wp_q[1]);
                    grant    = sr_write;
                    load     = CNT_W'(T_WRSR);
                end
                OP_PP: begin
                    grant = (nbytes >= NB_W'(5)) && (nbytes <= NB_W'(PAGE_BYTES + 4))
                            && wel_q && !prot_hit;
                    load  = CNT_W'(T_PROG);
                end
                OP_SE, OP_BE: grant = (nbytes == NB_W'(4)) && wel_q && !prot_hit;
                OP_CE:        grant = (nbytes == NB_W'(1)) && wel_q && (level_q == 3'd0);
                default: ;
            endcase
        end
    end

    // Purpose: update the latch, lock bit and protect level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q   <= 1'b0;
            lock_q  <= 1'b0;
            level_q <= 3'd0;
        end else begin
            if (done)         wel_q <= 1'b0;
            else if (set_wel) wel_q <= 1'b1;
            else if (clr_wel) wel_q <= 1'b0;
            if (sr_write) begin
                lock_q  <= arg[7];
                level_q <= arg[4:2];
            end
        end
    end

    AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> wel_q); // R10
    AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wel_q); // R4
    AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !wp_q[1]) |=> $stable({lock_q, level_q})); // R5
    AST_BUSY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_end)); // R11
    AST_CHIP_ERASE_UNGUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(opcode) == OP_CE) |-> (level_q == 3'd0)); // R9
endmodule

// File: tb/sim_fsr_ctrl.sv
// Bench: behavioural model of status and busy window, busy compared every clock.
module sim_fsr_ctrl;
    localparam int H  = 6;
    localparam int TP = 300;
    localparam int TE = 600;
    localparam int TS = 200;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, busy;

    fsr_ctrl #(.T_PROG(TP), .T_ERASE(TE), .T_WRSR(TS)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .busy(busy)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    bit done_flag = 0;
    bit chk_on = 0, mode3 = 0;
    bit m_lock = 0, m_wel = 0, m_pend = 0;
    bit [2:0] m_lvl = 0;
    int m_from = 0, m_until = 0;
    logic [7:0] tx [0:299];
    logic [7:0] rx [0:299];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit guarded(input bit [2:0] lv, input logic [16:0] a);
        case (lv)
            3'd0:    return 1'b0;
            3'd1:    return a >= 17'h18000;
            3'd2:    return a >= 17'h10000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_lock, 2'b00, m_lvl, m_wel, (cyc >= m_from && cyc < m_until)};
    endfunction

    task automatic start_busy(input int c, input int t);
        m_from  = c + 3;
        m_until = c + 3 + t;
        m_pend  = 1;
    endtask

    // model of the decision taken when chip select rises at negedge cyc=c
    task automatic model_apply(input int c, input int nb, input int extra);
        logic [16:0] a;
        bit bz;
        if (m_pend && m_until <= c + 2) begin m_wel = 0; m_pend = 0; end
        bz = (c + 2 >= m_from) && (c + 2 < m_until);
        if (extra != 0 || nb == 0 || bz) return;
        a = {tx[1][0], tx[2], tx[3]};
        case (tx[0])
            8'h06: if (nb == 1) m_wel = 1;
            8'h04: if (nb == 1) m_wel = 0;
            8'h01: if (nb == 2 && m_wel && !(m_lock && !wp_n)) begin
                       m_lock = tx[1][7];
                       m_lvl  = tx[1][4:2];
                       start_busy(c, TS);
                   end
            8'h02: if (nb >= 5 && nb <= 260 && m_wel && !guarded(m_lvl, a)) start_busy(c, TP);
            8'h20, 8'h52: if (nb == 4 && m_wel && !guarded(m_lvl, a)) start_busy(c, TE);
            8'hC7: if (nb == 1 && m_wel && m_lvl == 3'd0) start_busy(c, TE);
            default: ;
        endcase
    endtask

    task automatic frame(input int nb, input int extra);
        sck = mode3;
        wait_clk(H);
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nb * 8 + extra; i++) begin
            sck  = 1'b0;
            mosi = tx[i / 8][7 - (i % 8)];
            wait_clk(H);
            rx[i / 8][7 - (i % 8)] = miso;
            sck = 1'b1;
            wait_clk(H);
        end
        if (!mode3) sck = 1'b0;
        wait_clk(H);
        cs_n = 1'b1;
        model_apply(cyc, nb, extra);
        wait_clk(4 * H);
    endtask

    task automatic cmd1(input logic [7:0] op);
        tx[0] = op;
        frame(1, 0);
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a, input int ndata);
        tx[0] = op; tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
        for (int i = 0; i < ndata; i++) tx[4 + i] = 8'(i * 7 + 3);
        frame(4 + ndata, 0);
    endtask

    task automatic wrsr(input logic [7:0] d);
        tx[0] = 8'h01; tx[1] = d;
        frame(2, 0);
    endtask

    task automatic wait_idle();
        while (cyc < m_until + 2) @(negedge clk);
    endtask

    task automatic rd_check(input string req, input int lit);
        tx[0] = 8'h05; tx[1] = 8'h00;
        frame(2, 0);
        chk(req, rx[1], exp_status());
        chk(req, rx[1], lit);
    endtask

    task automatic poll(input string req);
        int guard = 0;
        do begin
            tx[0] = 8'h05;
            frame(4, 0);
            guard++;
        end while (rx[3][0] !== 1'b0 && guard < 40);
        chk(req, int'(guard < 40), 1);
    endtask

    // R13: busy compared to the model window on every clock
    always @(negedge clk) begin
        if (chk_on) begin
            if (m_pend && cyc >= m_until) begin m_wel = 0; m_pend = 0; end
            chk("R13 busy window", int'(busy), int'(cyc >= m_from && cyc < m_until));
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 300; i++) tx[i] = 8'h00;
        wait_clk(5);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 miso in reset", int'(miso), 0);
        rst_n = 1'b1;
        wait_clk(3);
        chk_on = 1;

        rd_check("R1 status after reset", 8'h00);
        cmd1(8'h06);
        rd_check("R3 latch set", 8'h02);
        cmd1(8'h04);
        rd_check("R3 latch cleared", 8'h00);
        tx[0] = 8'h06; tx[1] = 8'h00;
        frame(2, 0);
        rd_check("R3 two-byte enable ignored", 8'h00);

        cmd_addr(8'h02, 24'h000100, 1);
        rd_check("R10 program without latch", 8'h00);

        mode3 = 1;
        cmd1(8'h06);
        wrsr(8'hEF);
        tx[0] = 8'h05;
        frame(4, 0);
        chk("R4 status during write", rx[1], 8'h8F);
        chk("R2 repeated status byte", rx[2], 8'h8C);
        chk("R2 repeated status byte", rx[3], 8'h8C);

        wp_n = 1'b0;
        wait_clk(10);
        cmd1(8'h06);
        wrsr(8'h00);
        rd_check("R5 locked write ignored", 8'h8E);
        wp_n = 1'b1;
        wait_clk(10);
        wrsr(8'h04);
        wait_idle();
        rd_check("R5 write accepted with pin high", 8'h04);

        cmd1(8'h06);
        cmd_addr(8'h20, 24'h01F000, 0);
        rd_check("R8 level1 top block guarded", 8'h06);
        cmd_addr(8'h20, 24'h017000, 0);
        poll("R7 sector erase completes");
        rd_check("R7 sector erase done", 8'h04);

        cmd1(8'h06);
        cmd_addr(8'h52, 24'h000000, 0);
        wrsr(8'h10);
        wait_idle();
        rd_check("R12 status write while busy ignored", 8'h04);

        cmd1(8'h06);
        wrsr(8'h08);
        wait_idle();
        cmd1(8'h06);
        cmd_addr(8'h52, 24'h010000, 0);
        rd_check("R8 level2 upper half guarded", 8'h0A);
        cmd_addr(8'h52, 24'h008000, 0);
        poll("R7 block erase completes");
        rd_check("R7 block erase done", 8'h08);

        mode3 = 0;
        cmd1(8'h06);
        cmd_addr(8'h02, 24'h000100, 0);
        rd_check("R6 program with no data ignored", 8'h0A);
        cmd_addr(8'h02, 24'h000100, 257);
        rd_check("R6 program over 256 bytes ignored", 8'h0A);
        cmd_addr(8'h02, 24'h000200, 256);
        wait_idle();
        rd_check("R6 full page program done", 8'h08);
        cmd1(8'h06);
        cmd_addr(8'h02, 24'h000300, 1);
        wait_idle();
        rd_check("R6 one byte program done", 8'h08);

        cmd1(8'h06);
        cmd1(8'hC7);
        rd_check("R9 chip erase guarded", 8'h0A);
        wrsr(8'h00);
        wait_idle();
        cmd1(8'h06);
        cmd1(8'hC7);
        wait_idle();
        rd_check("R9 chip erase done", 8'h00);

        tx[0] = 8'h06; tx[1] = 8'hFF;
        frame(1, 3);
        rd_check("R11 partial byte frame ignored", 8'h00);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule